// File: doc/BRIEF.md
# Buck-Boost Gate Sequencer

This block generates the four gate enables of a non-inverting buck-boost power stage. The two switches on the input side (Q1 high, Q2 low) form one complementary pair, and the two on the output side (Q3 low, Q4 high) form the other. A free-running 8-bit counter sets a 256-cycle switching period. In each period the requested duty word is clamped to a window chosen by the operating mode, and one switch of the active pair is modulated with it. The rectifier switch of that pair conducts only when a per-cycle condition allows. The switches of the idle pair are parked in fixed states.

Each pair has its own break-before-make logic. Before either switch of a pair may turn on, both must have been off for a programmable number of clock cycles. A request to change mode is sampled only when the period wraps. At that point every gate is forced off for one dead-time interval before the new mode begins driving. The regulation loop, the current comparator and the mode decision are outside this block and arrive as digital inputs.

Top module: `bbsq_top`

## Requirements
- R1: While `rst_n` is low all four gates are 0. After release, all gates stay 0 for at least `dead_cyc` cycles.
- R2: In buck mode (`mode_sel`=0), the duty word D is clamped to 26..253. Q1 is high during counter values below D. In steady state Q1 is high for D cycles of every 256, or D−`dead_cyc` cycles when Q2 conducted at the end of the previous period.
- R3: In buck mode, Q2 may conduct in the off phase of a period only if `peak_hit` was high during an on-phase cycle of that same period. In steady state it is then high for 256−D−`dead_cyc` cycles. A `peak_hit` seen only in the off phase has no effect. The latch is cleared at every period start.
- R4: Q1 and Q2 are never high together. Each handover between them leaves both low for at least `dead_cyc` cycles.
- R5: In buck mode Q3 is held low and Q4 is held high.
- R6: In boost mode (`mode_sel`=1), D is clamped to 13..217 and Q3 is modulated the way R2 describes for Q1.
- R7: In boost mode Q4 conducts in the off phase only while `low_vin` is high (256−D−`dead_cyc` cycles per period). Otherwise it stays low.
- R8: Q3 and Q4 are never high together. Each handover between them leaves both low for at least `dead_cyc` cycles.
- R9: In boost mode Q2 is held low and Q1 is held high.
- R10: `mode_sel` is sampled only at the period wrap. A change drives all four gates low for exactly `dead_cyc` cycles, and then the new mode takes over.
- R11: The dead time is the 4-bit count `dead_cyc`. Changing it changes the pulse widths of R2, R3, R6 and R7 accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = buck, 1 = boost |
| duty_req | input | 8 | Requested duty, in 1/256 steps |
| dead_cyc | input | 4 | Dead time in clock cycles |
| peak_hit | input | 1 | Peak-current comparator flag |
| low_vin | input | 1 | Low-input-voltage flag |
| gate_q1 | output | 1 | Input-side high switch enable |
| gate_q2 | output | 1 | Input-side low switch enable |
| gate_q3 | output | 1 | Output-side low switch enable |
| gate_q4 | output | 1 | Output-side high switch enable |

## Verification
Duty, mode, dead time and both flags act on the gates one register stage after the counter. A new duty or mode therefore shows only from the next period wrap, and the steady pattern is settled by the second period. The vector walk waits three full periods after each change and then counts gate-high cycles over a 256-cycle window. Because a steady pattern repeats every period, this count does not depend on the window's phase. The directed tests lock onto an observed rising edge, which marks counter value 0 delayed by one cycle. From that edge they count exact cycle offsets: the mode change must first show 256 cycles after it, and the rectifier window starts D+`dead_cyc` cycles after it.

// File: rtl/bbsq_pkg.sv
package bbsq_pkg;
    typedef enum logic {
        MODE_BUCK  = 1'b0,
        MODE_BOOST = 1'b1
    } conv_mode_e;
endpackage

// File: rtl/bbsq_pwm.sv
module bbsq_pwm
    import bbsq_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int DT_W         = 4,
    parameter int BUCK_MIN_PCT = 10,
    parameter int BUCK_MAX_PCT = 99,
    parameter int BST_MIN_PCT  = 5,
    parameter int BST_MAX_PCT  = 85
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_req,
    input  logic [CNT_W-1:0] duty_req,
    input  logic [DT_W-1:0]  dead_cyc,
    input  logic             peak_hit,
    output conv_mode_e       mode_o,
    output logic             on_phase,
    output logic             peak_seen,
    output logic             blank
);
    localparam int PERIOD = 2 ** CNT_W;
    localparam logic [CNT_W-1:0] BUCK_LO = CNT_W'((BUCK_MIN_PCT * PERIOD + 99) / 100);
    localparam logic [CNT_W-1:0] BUCK_HI = CNT_W'((BUCK_MAX_PCT * PERIOD) / 100);
    localparam logic [CNT_W-1:0] BST_LO  = CNT_W'((BST_MIN_PCT * PERIOD + 99) / 100);
    localparam logic [CNT_W-1:0] BST_HI  = CNT_W'((BST_MAX_PCT * PERIOD) / 100);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] duty;
        conv_mode_e       mode;
        logic [DT_W-1:0]  blank_cnt;
        logic             pk;
    } pwm_st_t;

    pwm_st_t s_d, s_q;

    function automatic logic [CNT_W-1:0] clamp_duty(input logic [CNT_W-1:0] d,
                                                    input conv_mode_e m);
        logic [CNT_W-1:0] lo, hi;
        lo = (m == MODE_BOOST) ? BST_LO : BUCK_LO;
        hi = (m == MODE_BOOST) ? BST_HI : BUCK_HI;
        if (d < lo)      return lo;
        else if (d > hi) return hi;
        else             return d;
    endfunction

    logic on_ph;
    logic wrap;
    conv_mode_e req_mode;

    always_comb begin
        req_mode = conv_mode_e'(mode_req);
        on_ph    = s_q.cnt < s_q.duty;
        wrap     = s_q.cnt == '1;
        s_d      = s_q;
        s_d.cnt  = s_q.cnt + 1'b1;
        s_d.pk   = s_q.pk | (peak_hit & on_ph);
        if (s_q.blank_cnt != '0) begin
            s_d.blank_cnt = s_q.blank_cnt - 1'b1;
        end
        if (wrap) begin
            s_d.duty      = clamp_duty(duty_req, req_mode);
            s_d.mode      = req_mode;
            s_d.blank_cnt = (req_mode != s_q.mode) ? dead_cyc : '0;
            s_d.pk        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt       <= '1;
            s_q.duty      <= BUCK_LO;
            s_q.mode      <= MODE_BUCK;
            s_q.blank_cnt <= '0;
            s_q.pk        <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o    = s_q.mode;
    assign on_phase  = on_ph;
    assign peak_seen = s_q.pk;
    assign blank     = s_q.blank_cnt != '0;
endmodule

// File: rtl/bbsq_pair.sv
module bbsq_pair #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            want_main,
    input  logic            want_rect,
    input  logic [DT_W-1:0] dead_cyc,
    output logic            gate_main,
    output logic            gate_rect
);
    typedef struct packed {
        logic            main;
        logic            rect;
        logic [DT_W-1:0] idle;
    } pair_st_t;

    pair_st_t s_d, s_q;
    logic may_start;

    always_comb begin
        may_start = s_q.idle >= dead_cyc;
        s_d       = s_q;
        s_d.main  = want_main && (s_q.main || (!s_q.rect && may_start));
        s_d.rect  = want_rect && !want_main && (s_q.rect || (!s_q.main && may_start));
        if (s_d.main || s_d.rect) begin
            s_d.idle = '0;
        end else if (s_q.idle != '1) begin
            s_d.idle = s_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_main = s_q.main;
    assign gate_rect = s_q.rect;
endmodule

// File: rtl/bbsq_top.sv
module bbsq_top
    import bbsq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic [CNT_W-1:0] duty_req,
    input  logic [DT_W-1:0]  dead_cyc,
    input  logic             peak_hit,
    input  logic             low_vin,
    output logic             gate_q1,
    output logic             gate_q2,
    output logic             gate_q3,
    output logic             gate_q4
);
    localparam int NPAIR = 2;

    conv_mode_e cur_mode;
    logic on_phase, peak_seen, blank;
    logic [NPAIR-1:0] want_m, want_r, gate_m, gate_r;

    bbsq_pwm #(.CNT_W(CNT_W), .DT_W(DT_W)) u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_req  (mode_sel),
        .duty_req  (duty_req),
        .dead_cyc  (dead_cyc),
        .peak_hit  (peak_hit),
        .mode_o    (cur_mode),
        .on_phase  (on_phase),
        .peak_seen (peak_seen),
        .blank     (blank)
    );

    // pair 0: Q1 modulated / Q2 rectifier; pair 1: Q3 modulated / Q4 rectifier
    always_comb begin
        if (cur_mode == MODE_BUCK) begin
            want_m[0] = on_phase;
            want_r[0] = !on_phase && peak_seen;
            want_m[1] = 1'b0;
            want_r[1] = 1'b1;
        end else begin
            want_m[0] = 1'b1;
            want_r[0] = 1'b0;
            want_m[1] = on_phase;
            want_r[1] = !on_phase && low_vin;
        end
        if (blank) begin
            want_m = '0;
            want_r = '0;
        end
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        bbsq_pair #(.DT_W(DT_W)) u_pair (
            .clk       (clk),
            .rst_n     (rst_n),
            .want_main (want_m[p]),
            .want_rect (want_r[p]),
            .dead_cyc  (dead_cyc),
            .gate_main (gate_m[p]),
            .gate_rect (gate_r[p])
        );
    end

    assign gate_q1 = gate_m[0];
    assign gate_q2 = gate_r[0];
    assign gate_q3 = gate_m[1];
    assign gate_q4 = gate_r[1];
endmodule

// File: rtl/bbsq_chk.sv
module bbsq_chk
    import bbsq_pkg::*;
#(
    parameter int DT_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DT_W-1:0] dead_cyc,
    input conv_mode_e      mode_now,
    input logic            gate_q1,
    input logic            gate_q2,
    input logic            gate_q3,
    input logic            gate_q4
);
    logic [DT_W:0] off_a, off_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_a <= '0;
            off_b <= '0;
        end else begin
            off_a <= (gate_q1 || gate_q2) ? '0 : ((off_a == '1) ? off_a : off_a + 1'b1);
            off_b <= (gate_q3 || gate_q4) ? '0 : ((off_b == '1) ? off_b : off_b + 1'b1);
        end
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_gates_chk: assert (!gate_q1 && !gate_q2 && !gate_q3 && !gate_q4);
        end
    end

    // R4
    in_pair_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_q1 && gate_q2));

    // R8
    out_pair_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_q3 && gate_q4));

    // R4
    q1_dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q1) |-> (off_a >= {1'b0, dead_cyc}));

    // R4
    q2_dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q2) |-> (off_a >= {1'b0, dead_cyc}));

    // R8
    q3_dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q3) |-> (off_b >= {1'b0, dead_cyc}));

    // R8
    q4_dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q4) |-> (off_b >= {1'b0, dead_cyc}));

    // R5
    buck_q3_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_now == MODE_BUCK && $past(mode_now) == MODE_BUCK) |-> !gate_q3);

    // R9
    boost_q2_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_now == MODE_BOOST && $past(mode_now) == MODE_BOOST) |-> !gate_q2);
endmodule

bind bbsq_top bbsq_chk #(.DT_W(DT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dead_cyc (dead_cyc),
    .mode_now (cur_mode),
    .gate_q1  (gate_q1),
    .gate_q2  (gate_q2),
    .gate_q3  (gate_q3),
    .gate_q4  (gate_q4)
);

// File: tb/sim_bbsq_top.sv
`timescale 1ns/1ps
module sim_bbsq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic [7:0] duty_req = 8'd100;
    logic [3:0] dead_cyc = 4'd3;
    logic       peak_hit = 1'b0;
    logic       low_vin = 1'b0;
    logic       gate_q1, gate_q2, gate_q3, gate_q4;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bbsq_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .duty_req (duty_req),
        .dead_cyc (dead_cyc),
        .peak_hit (peak_hit),
        .low_vin  (low_vin),
        .gate_q1  (gate_q1),
        .gate_q2  (gate_q2),
        .gate_q3  (gate_q3),
        .gate_q4  (gate_q4)
    );

    typedef struct packed {
        logic       mode;
        logic [7:0] duty;
        logic [3:0] dt;
        logic       pk;
        logic       lv;
        logic [8:0] e1;
        logic [8:0] e2;
        logic [8:0] e3;
        logic [8:0] e4;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'd100, 4'd3, 1'b1, 1'b0, 9'd97,  9'd153, 9'd0,   9'd256},
        '{1'b0, 8'd100, 4'd3, 1'b0, 1'b0, 9'd100, 9'd0,   9'd0,   9'd256},
        '{1'b0, 8'd5,   4'd3, 1'b0, 1'b0, 9'd26,  9'd0,   9'd0,   9'd256},
        '{1'b0, 8'd255, 4'd3, 1'b1, 1'b0, 9'd253, 9'd0,   9'd0,   9'd256},
        '{1'b0, 8'd200, 4'd3, 1'b1, 1'b1, 9'd197, 9'd53,  9'd0,   9'd256},
        '{1'b1, 8'd100, 4'd3, 1'b0, 1'b1, 9'd256, 9'd0,   9'd97,  9'd153},
        '{1'b1, 8'd100, 4'd3, 1'b1, 1'b0, 9'd256, 9'd0,   9'd100, 9'd0},
        '{1'b1, 8'd0,   4'd3, 1'b0, 1'b1, 9'd256, 9'd0,   9'd10,  9'd240},
        '{1'b1, 8'd255, 4'd3, 1'b0, 1'b1, 9'd256, 9'd0,   9'd214, 9'd36},
        '{1'b1, 8'd255, 4'd3, 1'b0, 1'b0, 9'd256, 9'd0,   9'd217, 9'd0},
        '{1'b1, 8'd100, 4'd6, 1'b0, 1'b1, 9'd256, 9'd0,   9'd94,  9'd150},
        '{1'b0, 8'd100, 4'd6, 1'b1, 1'b0, 9'd94,  9'd150, 9'd0,   9'd256}
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sync_rise_q1();
        while (gate_q1 !== 1'b0) @(negedge clk);
        while (gate_q1 !== 1'b1) @(negedge clk);
    endtask

    task automatic sync_rise_q3();
        while (gate_q3 !== 1'b0) @(negedge clk);
        while (gate_q3 !== 1'b1) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c1, c2, c3, c4, ovl, hold, offs;
        // R1: gates off during reset and for dead_cyc cycles after release
        cycles(3);
        check("R1", "gates in reset", {gate_q1, gate_q2, gate_q3, gate_q4}, 0);
        rst_n = 1'b1;
        offs = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!gate_q1 && !gate_q2 && !gate_q3 && !gate_q4) offs++;
        end
        check("R1", "off cycles after release", offs, 3);

        // vector walk: steady-state gate-high counts over one period
        for (int v = 0; v < NVEC; v++) begin
            mode_sel = VECS[v].mode;
            duty_req = VECS[v].duty;
            dead_cyc = VECS[v].dt;
            peak_hit = VECS[v].pk;
            low_vin  = VECS[v].lv;
            cycles(768);
            c1 = 0; c2 = 0; c3 = 0; c4 = 0; ovl = 0;
            for (int i = 0; i < 256; i++) begin
                @(negedge clk);
                c1 += int'(gate_q1);
                c2 += int'(gate_q2);
                c3 += int'(gate_q3);
                c4 += int'(gate_q4);
                if ((gate_q1 && gate_q2) || (gate_q3 && gate_q4)) ovl++;
            end
            if (VECS[v].mode == 1'b0) begin
                check((VECS[v].dt != 4'd3) ? "R11" : "R2", $sformatf("vec%0d q1", v), c1, int'(VECS[v].e1));
                check("R3", $sformatf("vec%0d q2", v), c2, int'(VECS[v].e2));
                check("R5", $sformatf("vec%0d q3", v), c3, int'(VECS[v].e3));
                check("R5", $sformatf("vec%0d q4", v), c4, int'(VECS[v].e4));
            end else begin
                check("R9", $sformatf("vec%0d q1", v), c1, int'(VECS[v].e1));
                check("R9", $sformatf("vec%0d q2", v), c2, int'(VECS[v].e2));
                check((VECS[v].dt != 4'd3) ? "R11" : "R6", $sformatf("vec%0d q3", v), c3, int'(VECS[v].e3));
                check("R7", $sformatf("vec%0d q4", v), c4, int'(VECS[v].e4));
            end
            check("R4", $sformatf("vec%0d pair overlap (R8)", v), ovl, 0);
        end

        // R10: mode request mid-period waits for wrap, then dead_cyc all-off cycles
        mode_sel = 1'b1; duty_req = 8'd100; dead_cyc = 4'd3; peak_hit = 1'b0; low_vin = 1'b0;
        cycles(768);
        sync_rise_q3();
        hold = 0; offs = 0;
        for (int i = 1; i <= 259; i++) begin
            @(negedge clk);
            if (i == 150) mode_sel = 1'b0;
            if (i >= 150 && i <= 255 && gate_q1) hold++;
            if (i >= 256 && i <= 258 && !gate_q1 && !gate_q2 && !gate_q3 && !gate_q4) offs++;
            if (i == 259) check("R10", "q1/q4 after blank", {gate_q1, gate_q2, gate_q3, gate_q4}, 4'b1001);
        end
        check("R10", "q1 held until wrap", hold, 106);
        check("R10", "all-off cycles", offs, 3);

        // R3: peak flag only in off phase is ignored
        cycles(768);
        sync_rise_q1();
        c2 = 0;
        for (int i = 1; i <= 511; i++) begin
            peak_hit = (i >= 150 && i <= 200);
            @(negedge clk);
            c2 += int'(gate_q2);
        end
        peak_hit = 1'b0;
        check("R3", "off-phase peak ignored", c2, 0);

        // R3: single on-phase pulse enables this period only
        cycles(512);
        sync_rise_q1();
        c2 = 0; c4 = 0;
        for (int i = 1; i <= 511; i++) begin
            peak_hit = (i == 50);
            @(negedge clk);
            if (i <= 255) c2 += int'(gate_q2);
            else          c4 += int'(gate_q2);
        end
        peak_hit = 1'b0;
        check("R3", "on-phase pulse period", c2, 153);
        check("R3", "next period cleared", c4, 0);

        // R1: asynchronous reset mid-run in boost
        mode_sel = 1'b1; low_vin = 1'b1;
        cycles(768);
        check("R9", "q1 on before reset", int'(gate_q1), 1);
        rst_n = 1'b0;
        #1;
        check("R1", "gates after mid-run reset", {gate_q1, gate_q2, gate_q3, gate_q4}, 0);
        cycles(2);
        rst_n = 1'b1;
        cycles(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule